// File: doc/BRIEF.md
# PWM Output Action Stage with Continuous Software Override

This block turns the running value of an external time-base counter into two PWM outputs, A and B. The time base supplies the count, its direction, and one-cycle strobes for the zero and period points. The block holds one compare register per channel and detects an up-count compare match when the count equals that register while the counter climbs. Each channel has an action word that sets, per event, what the output does: nothing, drive low, drive high or toggle. When several events land on one cycle, a fixed priority picks the action that applies.

A continuous software override can pin either output low or high whatever the events say. Software writes the override levels together with a reload selector. The written levels wait in a shadow register and move to the active override at the chosen point: counter zero, counter period, either of those, or the very next clock. A channel is switched off by writing an immediate force-low.

Top module: `aqsf_top`

## Requirements
- R1: While reset is asserted, both outputs are low, both compare registers and the shadow and active override are zero, and the reload selector is zero (load at zero).
- R2: An action code of 2 bits means 00 hold, 01 drive low, 10 drive high, 11 invert. The output is registered: an event in cycle n changes the output at the clock edge that ends cycle n, and with no event and no active override the output holds.
- R3: In each action word, bits 1:0 give the zero-event action and bits 3:2 the period-event action.
- R4: A compare event for a channel occurs when `tb_up` is 1 and `tb_cnt` equals that channel's compare register. Channel A reacts only to compare A using bits 5:4 of `act_a`; channel B reacts only to compare B using bits 9:8 of `act_b`. Bits 9:6 of `act_a` and bits 7:4 of `act_b` have no effect.
- R5: No compare event occurs while `tb_up` is 0, even when the count equals the compare value.
- R6: When events coincide, the compare action wins over the period action, which wins over the zero action. An event whose code is 00 requests nothing, so a lower-priority event with a non-zero code then applies.
- R7: Word value 0x01A on A (0x10A on B) gives an output that is high from zero up to the compare match and low after it; 0x025 on A (0x205 on B) gives the inverse waveform.
- R8: The active override uses bits 1:0 for A and bits 3:2 for B of its 4-bit value: 01 forces low, 10 forces high, 00 and 11 release the channel. An active force decides the output at every edge and masks all event actions.
- R9: A write (`frc_wr`) puts `frc_wdata[3:0]` in the shadow and `frc_wdata[7:6]` in the reload selector. The selector in force for a cycle is the one being written, if any, otherwise the stored one. The shadow moves to the active override at the edge ending a cycle with: 00 a zero strobe, 01 a period strobe, 10 either strobe, 11 any cycle. Bits 5:4 of `frc_wdata` are ignored.
- R10: Writing force-low with reload 11 drives the channel low at the second clock edge after the write cycle, with no counter event needed.
- R11: `cmp_wr[0]` loads `cmp_wdata` into compare A and `cmp_wr[1]` into compare B at the edge ending the write cycle. The new value is used for matches from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_cnt | input | CW | Time-base count value |
| tb_up | input | 1 | 1 while the time base counts up |
| tb_zero | input | 1 | Strobe: count is at zero |
| tb_prd | input | 1 | Strobe: count is at the period value |
| cmp_wr | input | 2 | Compare write enables, bit 0 = A, bit 1 = B |
| cmp_wdata | input | CW | Compare write value |
| act_a | input | ACT_W | Action word for channel A |
| act_b | input | ACT_W | Action word for channel B |
| frc_wr | input | 1 | Override register write enable |
| frc_wdata | input | FRC_W | Override levels [3:0] and reload selector [7:6] |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The collisions of interest are a compare match on the same cycle as a zero or period strobe, and an override reload on the same cycle as an event that would otherwise move the output. The bench provokes the first by setting the compare register to 0 or to the period value. It provokes the second by writing overrides while the counter sits on or near a strobe, with each reload selector in turn. Both cases are judged every clock against a behavioural model that ranks queued events by priority and applies the override last.

// File: rtl/aqsf_pkg.sv
package aqsf_pkg;

  typedef enum logic [1:0] {
    AQ_HOLD   = 2'b00,
    AQ_LOW    = 2'b01,
    AQ_HIGH   = 2'b10,
    AQ_INVERT = 2'b11
  } aq_act_e;

  typedef enum logic [1:0] {
    LD_AT_ZERO   = 2'b00,
    LD_AT_PERIOD = 2'b01,
    LD_AT_EITHER = 2'b10,
    LD_AT_NEXT   = 2'b11
  } ld_sel_e;

  // action word field positions
  localparam int F_ZERO_LSB = 0;
  localparam int F_PRD_LSB  = 2;
  localparam int F_CMPA_LSB = 4;
  localparam int F_CMPB_LSB = 8;

  // override word layout
  localparam int FRC_W      = 8;
  localparam int FRC_LVL_W  = 4;
  localparam int FRC_LD_LSB = 6;

  // pick the action of the highest-ranked event that asks for something
  function automatic aq_act_e rank_action(input logic hit_c, input logic hit_p,
                                          input logic hit_z, input logic [1:0] code_c,
                                          input logic [1:0] code_p, input logic [1:0] code_z);
    aq_act_e sel;
    sel = AQ_HOLD;
    if (hit_z && code_z != 2'b00) sel = aq_act_e'(code_z);
    if (hit_p && code_p != 2'b00) sel = aq_act_e'(code_p);
    if (hit_c && code_c != 2'b00) sel = aq_act_e'(code_c);
    return sel;
  endfunction

  function automatic logic apply_action(input aq_act_e act, input logic cur);
    logic nxt;
    case (act)
      AQ_LOW:    nxt = 1'b0;
      AQ_HIGH:   nxt = 1'b1;
      AQ_INVERT: nxt = ~cur;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic force_on(input logic [1:0] lvl);
    return (lvl == 2'b01) || (lvl == 2'b10);
  endfunction

  function automatic logic reload_due(input ld_sel_e sel, input logic zero, input logic prd);
    logic due;
    case (sel)
      LD_AT_ZERO:   due = zero;
      LD_AT_PERIOD: due = prd;
      LD_AT_EITHER: due = zero | prd;
      default:      due = 1'b1;
    endcase
    return due;
  endfunction

endpackage

// File: rtl/aqsf_cmp_unit.sv
module aqsf_cmp_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] cnt,
  input  logic          up,
  output logic          hit
);
  logic [CW-1:0] cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmp_q <= '0;
    else if (wr) cmp_q <= wdata;
  end

  // up-count match only
  assign hit = up && (cnt == cmp_q);
endmodule

// File: rtl/aqsf_force_ctl.sv
module aqsf_force_ctl
  import aqsf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [FRC_W-1:0]     wdata,
  input  logic                 zero,
  input  logic                 prd,
  output logic [FRC_LVL_W-1:0] frc_act,
  output logic [1:0]           ld_sel_q,
  output logic                 load
);
  logic [FRC_LVL_W-1:0] shadow_q;
  logic [FRC_LVL_W-1:0] pend;
  logic [1:0]           sel_eff;
  wire unused_frc_bits = ^wdata[FRC_LD_LSB-1:FRC_LVL_W];

  always_comb begin
    pend    = wr ? wdata[FRC_LVL_W-1:0] : shadow_q;
    sel_eff = wr ? wdata[FRC_LD_LSB+:2] : ld_sel_q;
    load    = reload_due(ld_sel_e'(sel_eff), zero, prd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      ld_sel_q <= LD_AT_ZERO;
      frc_act  <= '0;
    end else begin
      shadow_q <= pend;
      ld_sel_q <= sel_eff;
      if (load) frc_act <= pend;
    end
  end
endmodule

// File: rtl/aqsf_chan.sv
module aqsf_chan
  import aqsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_c,
  input  logic       hit_p,
  input  logic       hit_z,
  input  logic [1:0] code_c,
  input  logic [1:0] code_p,
  input  logic [1:0] code_z,
  input  logic [1:0] frc,
  output logic       pwm
);
  aq_act_e act;
  logic    nxt;

  always_comb begin
    act = rank_action(hit_c, hit_p, hit_z, code_c, code_p, code_z);
    if (force_on(frc)) nxt = frc[1];
    else               nxt = apply_action(act, pwm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= nxt;
  end
endmodule

// File: rtl/aqsf_top.sv
module aqsf_top
  import aqsf_pkg::*;
#(
  parameter int CW    = 16,
  parameter int ACT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    tb_cnt,
  input  logic             tb_up,
  input  logic             tb_zero,
  input  logic             tb_prd,
  input  logic [1:0]       cmp_wr,
  input  logic [CW-1:0]    cmp_wdata,
  input  logic [ACT_W-1:0] act_a,
  input  logic [ACT_W-1:0] act_b,
  input  logic             frc_wr,
  input  logic [FRC_W-1:0] frc_wdata,
  output logic             pwm_a,
  output logic             pwm_b
);
  localparam int NCH = 2;

  // named internal events, visible to the checker
  logic [NCH-1:0]       cmp_hit;
  logic [NCH-1:0]       pwm_vec;
  logic [FRC_LVL_W-1:0] frc_act;
  logic [1:0]           ld_sel_q;
  logic                 frc_load;

  wire unused_act = ^{act_a[ACT_W-1:F_CMPA_LSB+2], act_b[F_CMPB_LSB-1:F_CMPA_LSB]};

  aqsf_force_ctl u_force (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (frc_wr),
    .wdata    (frc_wdata),
    .zero     (tb_zero),
    .prd      (tb_prd),
    .frc_act  (frc_act),
    .ld_sel_q (ld_sel_q),
    .load     (frc_load)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [1:0] code_c;
    logic [1:0] code_p;
    logic [1:0] code_z;

    assign code_c = (g == 0) ? act_a[F_CMPA_LSB+:2] : act_b[F_CMPB_LSB+:2];
    assign code_p = (g == 0) ? act_a[F_PRD_LSB+:2]  : act_b[F_PRD_LSB+:2];
    assign code_z = (g == 0) ? act_a[F_ZERO_LSB+:2] : act_b[F_ZERO_LSB+:2];

    aqsf_cmp_unit #(.CW(CW)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cmp_wr[g]),
      .wdata (cmp_wdata),
      .cnt   (tb_cnt),
      .up    (tb_up),
      .hit   (cmp_hit[g])
    );

    aqsf_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_c  (cmp_hit[g]),
      .hit_p  (tb_prd),
      .hit_z  (tb_zero),
      .code_c (code_c),
      .code_p (code_p),
      .code_z (code_z),
      .frc    (frc_act[2*g+:2]),
      .pwm    (pwm_vec[g])
    );
  end

  assign pwm_a = pwm_vec[0];
  assign pwm_b = pwm_vec[1];
endmodule

// File: rtl/aqsf_checks.sv
module aqsf_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       tb_up,
  input logic       tb_zero,
  input logic       tb_prd,
  input logic       frc_wr,
  input logic [1:0] act_cmp_a,
  input logic [1:0] cmp_hit,
  input logic [3:0] frc_act,
  input logic [1:0] ld_sel_q,
  input logic       pwm_a,
  input logic       pwm_b
);
  logic frc_a_on;
  assign frc_a_on = (frc_act[1:0] == 2'b01) || (frc_act[1:0] == 2'b10);

  p_reset_low_r1: assert property (@(posedge clk)
    (!rst_n ##1 !rst_n) |-> (!pwm_a && !pwm_b));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_hit[0] && !tb_zero && !tb_prd && !frc_a_on) |=> $stable(pwm_a));

  p_no_down_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_up |-> (cmp_hit == 2'b00));

  p_cmp_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit[0] && act_cmp_a == 2'b01 && !frc_a_on) |=> !pwm_a);

  p_force_low_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[1:0] == 2'b01) |=> !pwm_a);

  p_force_high_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[3:2] == 2'b10) |=> pwm_b);

  p_reload_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frc_wr && ld_sel_q == 2'b00 && !tb_zero) |=> $stable(frc_act));
endmodule

bind aqsf_top aqsf_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .tb_up     (tb_up),
  .tb_zero   (tb_zero),
  .tb_prd    (tb_prd),
  .frc_wr    (frc_wr),
  .act_cmp_a (act_a[5:4]),
  .cmp_hit   (cmp_hit),
  .frc_act   (frc_act),
  .ld_sel_q  (ld_sel_q),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b)
);

// File: tb/aqsf_top_bench.sv
`timescale 1ns/1ps
module aqsf_top_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] tb_cnt = 0;
  logic        tb_up = 0, tb_zero = 0, tb_prd = 0;
  logic [1:0]  cmp_wr = 0;
  logic [15:0] cmp_wdata = 0;
  logic [9:0]  act_a = 0, act_b = 0;
  logic        frc_wr = 0;
  logic [7:0]  frc_wdata = 0;
  logic        pwm_a, pwm_b;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  aqsf_top u_aqsf_top (.*);

  always #5 clk = ~clk;

  // behavioural reference state
  int m_cmp[2];
  int m_shadow, m_sel, m_act;
  int m_out[2];

  function automatic int next_level(int cur, bit hc, bit hp, bit hz, int cc, int cp, int cz, int f);
    int q[$];
    if (f == 1) return 0;
    if (f == 2) return 1;
    if (hc) q.push_back(cc);   // rank order: compare, period, zero
    if (hp) q.push_back(cp);
    if (hz) q.push_back(cz);
    foreach (q[i]) begin
      if (q[i] == 1) return 0;
      if (q[i] == 2) return 1;
      if (q[i] == 3) return 1 - cur;
    end
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmp[0] = 0; m_cmp[1] = 0; m_shadow = 0; m_sel = 0; m_act = 0;
      m_out[0] = 0; m_out[1] = 0;
    end else begin
      int pend, sel; bit ha, hb, ld;
      ha = tb_up && (int'(tb_cnt) == m_cmp[0]);
      hb = tb_up && (int'(tb_cnt) == m_cmp[1]);
      m_out[0] = next_level(m_out[0], ha, tb_prd, tb_zero, int'(act_a[5:4]),
                            int'(act_a[3:2]), int'(act_a[1:0]), m_act % 4);
      m_out[1] = next_level(m_out[1], hb, tb_prd, tb_zero, int'(act_b[9:8]),
                            int'(act_b[3:2]), int'(act_b[1:0]), m_act / 4);
      pend = frc_wr ? int'(frc_wdata[3:0]) : m_shadow;
      sel  = frc_wr ? int'(frc_wdata[7:6]) : m_sel;
      ld = (sel == 3) || (sel == 0 && tb_zero) || (sel == 1 && tb_prd) ||
           (sel == 2 && (tb_zero || tb_prd));
      if (ld) m_act = pend;
      m_shadow = pend; m_sel = sel;
      if (cmp_wr[0]) m_cmp[0] = int'(cmp_wdata);
      if (cmp_wr[1]) m_cmp[1] = int'(cmp_wdata);
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (int'(pwm_a) != m_out[0]) begin
        n_bad++; $display("FAIL %s pwm_a actual %0d expected %0d at %0t", cur_req, pwm_a, m_out[0], $time);
      end
      n_cmp++;
      if (int'(pwm_b) != m_out[1]) begin
        n_bad++; $display("FAIL %s pwm_b actual %0d expected %0d at %0t", cur_req, pwm_b, m_out[1], $time);
      end
    end
  end

  task automatic expect_bit(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++; $display("FAIL %s explicit check actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input int c, input bit up, input bit z, input bit p);
    @(negedge clk);
    tb_cnt = 16'(c); tb_up = up; tb_zero = z; tb_prd = p;
  endtask

  task automatic run_up(input int prd, input int nper);
    for (int k = 0; k < nper; k++)
      for (int c = 0; c <= prd; c++) step(c, 1, c == 0, c == prd);
  endtask

  task automatic run_down(input int prd, input int nper);
    for (int k = 0; k < nper; k++)
      for (int c = prd; c >= 0; c--) step(c, 0, c == 0, c == prd);
  endtask

  task automatic wr_cmp(input int idx, input int v);
    @(negedge clk); cmp_wr[idx] = 1'b1; cmp_wdata = 16'(v);
    @(negedge clk); cmp_wr = 2'b00;
  endtask

  task automatic wr_force(input logic [7:0] w);
    @(negedge clk); frc_wr = 1'b1; frc_wdata = w;
    @(negedge clk); frc_wr = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; $display("FAIL %s watchdog actual hung expected finished", cur_req);
    done = 1; summary(); $finish;
  end

  initial begin
    logic prev_b;
    // R1: reset state
    repeat (3) @(negedge clk);
    expect_bit(pwm_a, 1'b0, "R1"); expect_bit(pwm_b, 1'b0, "R1");
    rst_n = 1;
    run_up(9, 1);   // R1: zero compares and no actions: outputs stay low
    expect_bit(pwm_a, 1'b0, "R1");

    // R7 + R11: normal polarity waveform, compare writes
    cur_req = "R7";
    wr_cmp(0, 4); wr_cmp(1, 7);
    act_a = 10'h01A; act_b = 10'h10A;
    run_up(10, 3);
    cur_req = "R11";
    wr_cmp(0, 2); run_up(10, 2);
    cur_req = "R7";
    act_a = 10'h025; act_b = 10'h205;
    run_up(10, 3);

    // R2 / R3: toggle on zero, toggle on period, single-field words
    cur_req = "R2";
    act_a = 10'h003; act_b = 10'h00C; run_up(6, 4);
    cur_req = "R3";
    act_a = 10'h002; act_b = 10'h004; run_up(6, 2);
    act_a = 10'h008; act_b = 10'h001; run_up(6, 2);

    // R4: the other channel's compare field has no effect
    cur_req = "R4";
    wr_cmp(0, 3); wr_cmp(1, 5);
    act_a = 10'h300; act_b = 10'h030; run_up(8, 3);
    act_a = 10'h330; act_b = 10'h330; run_up(8, 3);

    // R5: no compare event on a down count
    cur_req = "R5";
    act_a = 10'h030; act_b = 10'h300; run_down(8, 3);

    // R6: compare coinciding with zero and with period
    cur_req = "R6";
    wr_cmp(0, 0); wr_cmp(1, 8);
    act_a = 10'h012; act_b = 10'h108; run_up(8, 2);
    step(5, 1, 0, 0);
    step(0, 1, 1, 0);
    @(negedge clk);
    expect_bit(pwm_a, 1'b0, "R6");   // compare low beats zero high
    act_a = 10'h002;                 // compare code 00 defers to zero high
    @(negedge clk);
    expect_bit(pwm_a, 1'b1, "R6");

    // R10: immediate force-low switches channel A off
    cur_req = "R10";
    wr_force(8'hC1);
    @(negedge clk);
    expect_bit(pwm_a, 1'b0, "R10");
    run_up(6, 2);
    expect_bit(pwm_a, 1'b0, "R10");
    wr_force(8'hC0);                 // release

    // R9: force B high waits for the period strobe
    cur_req = "R9";
    act_b = 10'h001;
    step(0, 1, 1, 0); step(3, 1, 0, 0);
    @(negedge clk); prev_b = pwm_b;
    expect_bit(pwm_b, 1'b0, "R9");
    wr_force(8'h78);                 // B high, bits 5:4 set (ignored), reload at period
    step(3, 1, 0, 0); step(3, 1, 0, 0);
    expect_bit(pwm_b, prev_b, "R9");
    step(9, 1, 0, 1); step(3, 1, 0, 0);
    @(negedge clk);
    expect_bit(pwm_b, 1'b1, "R9");

    // R8 / R9: override against running events, every selector and code
    cur_req = "R8";
    act_a = 10'h01A; act_b = 10'h10A; wr_cmp(0, 3); wr_cmp(1, 6);
    wr_force(8'h06); run_up(8, 2);   // A high, B low at zero
    wr_force(8'h8F); run_up(8, 2);   // 11 codes release at zero or period
    cur_req = "R9";
    wr_force(8'h09); run_up(8, 2);   // A low, B high at zero
    wr_force(8'h40); run_up(8, 2);   // release at period
    wr_force(8'h85); run_down(8, 2); // both low at either strobe
    wr_force(8'hC0); run_up(8, 2);

    done = 1;
    summary();
    $finish;
  end
endmodule